// File: doc/BRIEF.md
# DLL Calibration Lock-and-Freeze Sequencer

This block runs the calibration sequence for the delay-locked loop in a memory PHY. A single start pulse makes it issue three control words. The first loads the delay-line start point and the increment. The second switches the loop on. The third begins locking. The block then polls the PHY status word until every lock indicator is set. At that point it lifts the locked delay code out of the status word and writes it back in a fourth control word. That word forces the PHY to hold the measured delay.

An optional mode adds one more write after the forced word. This write leaves the forced value in place and turns the tracking loop off. A poll budget, taken when the start pulse is accepted, limits how long the block waits for lock. If the budget runs out, the block sets an error flag and drops back to idle without forcing anything. Each control word is presented for one cycle with a write strobe, so the PHY control register can be written directly.

Top module: `dll_lockfreeze_ctrl`

## Requirements
- R1: During and straight after reset, busy, done, error and the write strobe are all low.
- R2: The first write appears in the cycle after a start pulse is sampled in idle. It is 0x00101000: start point 0x10 in bits [15:8], increment 0x10 in bits [23:16], bits [1:0] zero.
- R3: Every write is a one-cycle strobe, and any two writes have at least one idle cycle between them. The second write is 0x00101002 (enable, bit 1). The third write is 0x00101003 (enable plus lock start, bit 0).
- R4: Polling counts the loop as locked only when status bits [2:0] all read 1. Any other pattern keeps the block polling.
- R5: After lock, the forced write carries status bits [13:6], from the locked poll cycle, in control bits [31:24], ORed with 0x00101003.
- R6: If off-mode is sampled high with the start pulse, one more write follows the forced write after a gap. It is the forced word with bit 1 cleared and bit 0 still set.
- R7: The poll limit L is sampled with start. If lock has not been seen after L+1 poll cycles, the error flag is set, no forced write is made and the block returns to idle. If lock arrives in the final poll cycle, lock wins.
- R8: Done rises in the cycle after the last write of a successful sequence. It stays high until the next accepted start, which also clears the error flag.
- R9: A start pulse that arrives while busy is ignored: it adds no writes and does not change the outcome.
- R10: Busy is high from the cycle after an accepted start until the sequence ends. Busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| off_mode_i | input | 1 | Turn tracking off after forcing (sampled at start) |
| poll_limit_i | input | TO_W | Poll budget L (sampled at start) |
| status_i | input | 32 | PHY status word |
| ctrl_word_o | output | 32 | PHY control word |
| ctrl_wr_o | output | 1 | Control word write strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed with lock |
| err_o | output | 1 | Lock timeout occurred |

## Verification
The lock detection and the poll-budget expiry can fall in the same poll cycle. The status stub raises all lock bits exactly in poll cycle L, so both conditions hold on one edge. The run is judged by whether the forced write and done appear and the error stays low. Lock arriving one cycle later must give the timeout outcome instead. Budgets of zero are included, so the clash also happens on the very first poll.

// File: rtl/dllf_pkg.sv
package dllf_pkg;
  localparam int CW = 32;
  localparam logic [7:0] START_PT = 8'h10;
  localparam logic [7:0] STEP_INC = 8'h10;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PARAM, ST_GAP1, ST_ON, ST_GAP2, ST_GO,
    ST_POLL, ST_FORCE, ST_GAP3, ST_OFF
  } seq_st_t;

  // parameter word: increment and start point, loop off
  function automatic logic [CW-1:0] base_word();
    return {8'h00, STEP_INC, START_PT, 8'h00};
  endfunction

  function automatic logic is_locked(input logic [CW-1:0] s);
    return &s[2:0];
  endfunction

  function automatic logic [7:0] lock_code(input logic [CW-1:0] s);
    return s[13:6];
  endfunction

  // code lands in [31:24]; bits 20 and 12 fixed; bit0 force, bit1 tracking
  function automatic logic [CW-1:0] frozen_word(input logic [7:0] code,
                                                input logic keep_track);
    return {code, 24'h0} | 32'h0010_0000 | 32'h0000_1000 |
           {30'b0, keep_track, 1'b1};
  endfunction
endpackage

// File: rtl/dllf_poll_timer.sv
module dllf_poll_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [TO_W-1:0] limit_i,
  input  logic            run_i,
  output logic            expired_o
);
  logic [TO_W-1:0] lim_q;
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      lim_q <= limit_i;
      cnt_q <= '0;
    end else if (run_i && cnt_q != lim_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run_i && (cnt_q == lim_q);
endmodule

// File: rtl/dllf_seq_fsm.sv
module dllf_seq_fsm
  import dllf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          off_mode_i,
  input  logic [CW-1:0] status_i,
  input  logic          tmo_i,
  output seq_st_t       st_o,
  output logic [7:0]    code_o,
  output logic          accept_o,
  output logic          lock_evt_o,
  output logic          tmo_evt_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  seq_st_t st_q, st_d;
  logic    mode_q;
  logic    done_q, err_q;
  logic [7:0] code_q;

  assign accept_o   = (st_q == ST_IDLE) && start_i;
  assign lock_evt_o = (st_q == ST_POLL) && is_locked(status_i);
  assign tmo_evt_o  = (st_q == ST_POLL) && !is_locked(status_i) && tmo_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_PARAM;
      ST_PARAM: st_d = ST_GAP1;
      ST_GAP1:  st_d = ST_ON;
      ST_ON:    st_d = ST_GAP2;
      ST_GAP2:  st_d = ST_GO;
      ST_GO:    st_d = ST_POLL;
      ST_POLL: begin
        if (lock_evt_o)     st_d = ST_FORCE;
        else if (tmo_evt_o) st_d = ST_IDLE;
      end
      ST_FORCE: st_d = mode_q ? ST_GAP3 : ST_IDLE;
      ST_GAP3:  st_d = ST_OFF;
      ST_OFF:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept_o) begin
        mode_q <= off_mode_i;
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (lock_evt_o) code_q <= lock_code(status_i);
      if (tmo_evt_o)  err_q  <= 1'b1;
      if ((st_q == ST_FORCE && !mode_q) || st_q == ST_OFF) done_q <= 1'b1;
    end
  end

  assign st_o   = st_q;
  assign code_o = code_q;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dllf_word_gen.sv
module dllf_word_gen
  import dllf_pkg::*;
(
  input  seq_st_t       st_i,
  input  logic [7:0]    code_i,
  output logic [CW-1:0] word_o,
  output logic          wr_o
);
  always_comb begin
    word_o = '0;
    wr_o   = 1'b1;
    unique case (st_i)
      ST_PARAM: word_o = base_word();
      ST_ON:    word_o = base_word() | 32'h2;
      ST_GO:    word_o = base_word() | 32'h3;
      ST_FORCE: word_o = frozen_word(code_i, 1'b1);
      ST_OFF:   word_o = frozen_word(code_i, 1'b0);
      default:  wr_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/dll_lockfreeze_ctrl.sv
module dll_lockfreeze_ctrl
  import dllf_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            off_mode_i,
  input  logic [TO_W-1:0] poll_limit_i,
  input  logic [31:0]     status_i,
  output logic [31:0]     ctrl_word_o,
  output logic            ctrl_wr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o
);
  seq_st_t    st_w;
  logic [7:0] code_w;
  logic       accept_w, lock_evt_w, tmo_evt_w, tmo_w;
  logic       force_wr_w;

  dllf_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .off_mode_i(off_mode_i),
    .status_i(status_i), .tmo_i(tmo_w), .st_o(st_w), .code_o(code_w),
    .accept_o(accept_w), .lock_evt_o(lock_evt_w), .tmo_evt_o(tmo_evt_w),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  dllf_poll_timer #(.TO_W(TO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(accept_w), .limit_i(poll_limit_i),
    .run_i(st_w == ST_POLL), .expired_o(tmo_w)
  );

  dllf_word_gen u_gen (
    .st_i(st_w), .code_i(code_w), .word_o(ctrl_word_o), .wr_o(ctrl_wr_o)
  );

  assign force_wr_w = (st_w == ST_FORCE);
endmodule

// File: rtl/dllf_chk.sv
module dllf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [31:0] status_i,
  input logic [31:0] ctrl_word_o,
  input logic        ctrl_wr_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        force_wr_w,
  input logic        tmo_evt_w,
  input logic        lock_evt_w
);
  // R3
  wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |=> !ctrl_wr_o);
  // R4
  lock_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr_w |-> $past(status_i[2:0]) == 3'b111);
  // R5
  force_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr_w |-> ctrl_wr_o && ctrl_word_o[31:24] == $past(status_i[13:6])
                   && ctrl_word_o[23:0] == 24'h101003);
  // R7
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt_w |=> !busy_o && err_o && !ctrl_wr_o);
  // R7
  lock_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt_w |=> force_wr_w && !err_o);
  // R8
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(ctrl_wr_o));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> !(ctrl_wr_o && ctrl_word_o == 32'h0010_1000));
  // R10
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
endmodule

bind dll_lockfreeze_ctrl dllf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_i(status_i),
  .ctrl_word_o(ctrl_word_o), .ctrl_wr_o(ctrl_wr_o), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .force_wr_w(force_wr_w),
  .tmo_evt_w(tmo_evt_w), .lock_evt_w(lock_evt_w)
);

// File: tb/tb_dll_lockfreeze_ctrl.sv
`timescale 1ns/1ps
module tb_dll_lockfreeze_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        off_mode_i = 1'b0;
  logic [15:0] poll_limit_i = '0;
  logic [31:0] status_i = '0;
  logic [31:0] ctrl_word_o;
  logic        ctrl_wr_o, busy_o, done_o, err_o;

  dll_lockfreeze_ctrl #(.TO_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .off_mode_i(off_mode_i),
    .poll_limit_i(poll_limit_i), .status_i(status_i),
    .ctrl_word_o(ctrl_word_o), .ctrl_wr_o(ctrl_wr_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected forced / off word, built by arithmetic
  function automatic logic [31:0] model_word(input logic [7:0] code, input bit keep);
    return (32'(code) << 24) + 32'h0010_1000 + (keep ? 32'd2 : 32'd0) + 32'd1;
  endfunction

  // behavioural status stub
  int         stub_after = 1;
  int         stub_cnt = 0;
  bit         stub_armed = 0;
  logic [7:0] stub_code = '0;
  logic [2:0] stub_partial = '0;
  always @(negedge clk) begin
    if (stub_armed) stub_cnt++;
    if (ctrl_wr_o && ctrl_word_o == 32'h0010_1003) begin
      stub_armed = 1;
      stub_cnt = 0;
    end
    if (stub_armed && stub_cnt >= stub_after)
      status_i = {18'h0, stub_code, 3'b000, 3'b111};
    else
      status_i = {18'h0, ~stub_code, 3'b000, stub_partial};
  end

  // monitor / scoreboard
  bit prev_wr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ctrl_wr_o) begin
        if (prev_wr) chk(0, "R3 back-to-back strobe", ctrl_word_o, 32'h0);
        if (exp_q.size() == 0) begin
          chk(0, "R9/R7 unexpected write", ctrl_word_o, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(ctrl_word_o == e, t, ctrl_word_o, e);
        end
      end
      prev_wr = ctrl_wr_o;
    end
  end

  task automatic run(input logic [7:0] code, input int after, input int limit,
                     input bit mode, input logic [2:0] partial,
                     input bit ok_exp, input bit poke_busy);
    stub_armed = 0;
    stub_code = code;
    stub_after = after;
    stub_partial = partial;
    exp_q.push_back(32'h0010_1000); tag_q.push_back("R2 param word");
    exp_q.push_back(32'h0010_1002); tag_q.push_back("R3 enable word");
    exp_q.push_back(32'h0010_1003); tag_q.push_back("R3 start word");
    if (ok_exp) begin
      exp_q.push_back(model_word(code, 1)); tag_q.push_back("R5 forced word");
      if (mode) begin
        exp_q.push_back(model_word(code, 0)); tag_q.push_back("R6 off word");
      end
    end
    @(negedge clk);
    off_mode_i = mode;
    poll_limit_i = 16'(limit);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after start", 32'(busy_o), 32'd1);
    chk(done_o == 1'b0 && err_o == 1'b0, "R8 flags cleared by start",
        {30'b0, done_o, err_o}, 32'd0);
    if (poke_busy) begin
      repeat (6) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    chk(done_o == ok_exp, "R8 done at end", 32'(done_o), 32'(ok_exp));
    chk(err_o == !ok_exp, "R7 error at end", 32'(err_o), 32'(!ok_exp));
    chk(exp_q.size() == 0, "R3/R5 all writes seen", 32'(exp_q.size()), 32'd0);
    repeat (5) @(negedge clk);
    chk(done_o == ok_exp && !busy_o, "R8 done held / R9 no restart",
        {30'b0, busy_o, done_o}, {31'b0, ok_exp});
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 32'h0, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, err_o, ctrl_wr_o} == 4'b0, "R1 in reset",
        {28'b0, busy_o, done_o, err_o, ctrl_wr_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, err_o, ctrl_wr_o} == 4'b0, "R1 after reset",
        {28'b0, busy_o, done_o, err_o, ctrl_wr_o}, 32'h0);
    run(8'h5A, 3, 20, 0, 3'b011, 1, 0);   // R5 plain lock
    run(8'hFF, 1, 20, 1, 3'b000, 1, 0);   // R6 first-poll lock, off mode
    run(8'h00, 4, 20, 1, 3'b110, 1, 0);   // R4 partial lock bits ignored
    run(8'hA5, 6, 4, 0, 3'b101, 0, 0);    // R7 timeout
    run(8'h3C, 5, 4, 1, 3'b011, 1, 0);    // R7 lock on final poll wins
    run(8'h81, 12, 30, 0, 3'b000, 1, 1);  // R9 start while busy
    run(8'h42, 1, 0, 0, 3'b001, 1, 0);    // R7 zero budget, lock on it
    run(8'h24, 2, 0, 1, 3'b011, 0, 0);    // R7 zero budget, timeout
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule